// File: doc/BRIEF.md
# GPIO Expander Register and Interrupt Core

This block is the register and interrupt heart of an 8-pin general-purpose I/O expander. A serial front end (outside this block) turns bus frames into single-cycle accesses on a simple synchronous register bus. That bus has an 8-bit address, 8-bit write and read data, and separate write and read strobes. The core holds the direction, polarity, output latch, pull-up, interrupt and configuration registers. It drives per-pin output data and output enables, and it reads pin inputs that are already synchronized.

Each input pin can raise an interrupt in one of two ways. In the first, it raises one when it differs from its value in the previous cycle. In the second, it raises one when it differs from a per-pin default bit. When an interrupt is raised, the core latches a one-hot flag for the first pin that caused it and takes a snapshot of the whole port. Both stay frozen until software clears the interrupt by reading either the port register or the snapshot register, depending on configuration. A single interrupt line leaves the block. Its active level and its drive style (push-pull or open-drain) are set by configuration.

For multi-byte transfers, the front end can assert a sequential strobe. The access then uses an internal address pointer instead of the bus address. When sequential operation is enabled, that pointer advances after every access.

Top module: `gpx_core`

## Requirements
- R1: After reset the direction register reads 0xFF and every other register reads 0x00. All pins are inputs (pin_oe = 0x00) and no interrupt is pending, so the interrupt line is driven (irq_oe = 1) at its inactive level, which is high.
- R2: The writable registers sit at these addresses: direction 0x00, polarity 0x01, interrupt enable 0x02, default value 0x03, interrupt control 0x04, configuration 0x05, pull-up 0x06, output latch 0x0A. Each reads back the byte last written. Read data appears on bus_rdata one cycle after the read strobe and holds until the next read.
- R3: The flag register (0x07) and the capture register (0x08) are read-only, and writes to them have no effect. Addresses above 0x0A read as 0x00 and ignore writes.
- R4: A pin whose interrupt-enable bit is 0 never sets a flag bit. The same applies to a pin whose direction bit is 0 (output).
- R5: With interrupt-control bit 0, an enabled input pin raises an interrupt when its port value differs from its value in the previous cycle.
- R6: With interrupt-control bit 1, an enabled input pin raises an interrupt when its port value differs from its default-value bit.
- R7: The flag register is one-hot or zero. It holds only the first causing pin; if several pins trigger in the same cycle, the lowest-numbered one is flagged. While the flag is nonzero, no other pin sets a flag bit.
- R8: When the interrupt is raised, the port value is copied into the capture register. The capture register stays unchanged while the interrupt is pending.
- R9: The clear-control bit is configuration bit 0. When it is 0, a read of the port (0x09) clears the flag and a read of the capture register does not. When it is 1, the roles are swapped.
- R10: A clear re-arms detection. A mismatch that is still present in default-compare mode sets the flag again on the following cycle.
- R11: Direction bit 1 means input and 0 means output. The port value is (pin_in XOR polarity) for input pins and the latch bit for output pins. Reading 0x0A returns the latch. Writing 0x09 writes the latch. pin_out equals the latch and pin_oe is the inverse of direction.
- R12: The interrupt output follows two configuration bits. When bit 2 (open-drain) is 1, irq_out = 0 and irq_oe = pending. Otherwise irq_oe = 1, and irq_out equals bit 1 (active-high select) while pending and its inverse while idle.
- R13: Configuration bit 5 disables sequential operation. With bus_seq = 1, an access uses the internal pointer instead of bus_addr. After any access, the pointer becomes the accessed address plus one, wrapping to 0x00 after 0x0A or above, or stays on the accessed address when bit 5 is 1. Reset sets the pointer to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address for non-sequential accesses |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe, one access per cycle |
| bus_seq | input | 1 | Use the internal pointer as the address |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Synchronized pin levels |
| pin_out | output | 8 | Per-pin output data |
| pin_oe | output | 8 | Per-pin output enable, 1 = drive |
| irq_out | output | 1 | Interrupt line level |
| irq_oe | output | 1 | Interrupt line drive enable |

## Verification
The hardest case to reach is the re-arm after a clear in default-compare mode. The clear and the new raise fall on back-to-back edges, so a read placed directly after the clearing read would see the flag low and miss the re-raise. The bench therefore leaves an idle cycle after every read. It then checks the flag both through the read path and through the interrupt line. A further case is a second pin changing while an interrupt is pending. The stimulus moves several pins at once and then moves another pin. This shows both the lowest-index choice and the frozen flag and capture contents. The reference model must agree with the design on every clock.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    parameter int GPX_W = 8;

    typedef logic [GPX_W-1:0] gpx_byte_t;

    localparam gpx_byte_t A_DIR  = 8'h00;
    localparam gpx_byte_t A_POL  = 8'h01;
    localparam gpx_byte_t A_IEN  = 8'h02;
    localparam gpx_byte_t A_DEFV = 8'h03;
    localparam gpx_byte_t A_ICTL = 8'h04;
    localparam gpx_byte_t A_CFG  = 8'h05;
    localparam gpx_byte_t A_PUP  = 8'h06;
    localparam gpx_byte_t A_FLAG = 8'h07;
    localparam gpx_byte_t A_CAP  = 8'h08;
    localparam gpx_byte_t A_PORT = 8'h09;
    localparam gpx_byte_t A_OLAT = 8'h0A;

    localparam int CFG_ICC     = 0;
    localparam int CFG_IPOL    = 1;
    localparam int CFG_ODR     = 2;
    localparam int CFG_SEQ_OFF = 5;

    typedef struct packed {
        gpx_byte_t dir;
        gpx_byte_t pol;
        gpx_byte_t ien;
        gpx_byte_t defv;
        gpx_byte_t ictl;
        gpx_byte_t cfg;
        gpx_byte_t pup;
        gpx_byte_t olat;
        gpx_byte_t flag;
        gpx_byte_t cap;
        gpx_byte_t prev;
        gpx_byte_t rdata;
        gpx_byte_t ptr;
    } gpx_state_t;
endpackage

// File: rtl/gpx_portview.sv
module gpx_portview #(
    parameter int W = 8
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] olat,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] view
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign view[i] = dir[i] ? (pin_in[i] ^ pol[i]) : olat[i];
    end
endmodule

// File: rtl/gpx_irq_detect.sv
module gpx_irq_detect #(
    parameter int W = 8
) (
    input  logic [W-1:0] view,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] defv,
    input  logic [W-1:0] ictl,
    input  logic [W-1:0] ien,
    input  logic [W-1:0] dir,
    output logic [W-1:0] first
);
    logic [W-1:0] mism;

    for (genvar i = 0; i < W; i++) begin : g_cmp
        assign mism[i] = ien[i] & dir[i] &
                         (ictl[i] ? (view[i] ^ defv[i]) : (view[i] ^ prev[i]));
    end

    // isolate lowest set bit: lowest pin index wins
    assign first = mism & (~mism + {{(W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/gpx_irq_drive.sv
module gpx_irq_drive (
    input  logic active,
    input  logic open_drain,
    input  logic act_high,
    output logic irq_out,
    output logic irq_oe
);
    always_comb begin
        if (open_drain) begin
            irq_out = 1'b0;
            irq_oe  = active;
        end else begin
            irq_out = active ? act_high : ~act_high;
            irq_oe  = 1'b1;
        end
    end
endmodule

// File: rtl/gpx_core.sv
module gpx_core
    import gpx_pkg::*;
#(
    parameter int W        = GPX_W,
    parameter int LAST_REG = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [7:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    input  logic         bus_we,
    input  logic         bus_re,
    input  logic         bus_seq,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic         irq_out,
    output logic         irq_oe
);
    localparam gpx_byte_t LAST_A = gpx_byte_t'(LAST_REG);

    gpx_state_t s_d, s_q;
    logic [W-1:0] view, first;
    gpx_byte_t    ea;
    logic         clr;

    gpx_portview #(.W(W)) u_view (
        .dir(s_q.dir), .pol(s_q.pol), .olat(s_q.olat),
        .pin_in(pin_in), .view(view)
    );

    gpx_irq_detect #(.W(W)) u_det (
        .view(view), .prev(s_q.prev), .defv(s_q.defv), .ictl(s_q.ictl),
        .ien(s_q.ien), .dir(s_q.dir), .first(first)
    );

    gpx_irq_drive u_drv (
        .active(|s_q.flag), .open_drain(s_q.cfg[CFG_ODR]),
        .act_high(s_q.cfg[CFG_IPOL]), .irq_out(irq_out), .irq_oe(irq_oe)
    );

    always_comb begin
        ea  = bus_seq ? s_q.ptr : bus_addr;
        clr = bus_re && ((ea == A_PORT && !s_q.cfg[CFG_ICC]) ||
                         (ea == A_CAP  &&  s_q.cfg[CFG_ICC]));
        s_d      = s_q;
        s_d.prev = view;

        if (clr) begin
            s_d.flag = '0;
        end else if (s_q.flag == '0 && first != '0) begin
            s_d.flag = first;
            s_d.cap  = view;
        end

        if (bus_re) begin
            case (ea)
                A_DIR:   s_d.rdata = s_q.dir;
                A_POL:   s_d.rdata = s_q.pol;
                A_IEN:   s_d.rdata = s_q.ien;
                A_DEFV:  s_d.rdata = s_q.defv;
                A_ICTL:  s_d.rdata = s_q.ictl;
                A_CFG:   s_d.rdata = s_q.cfg;
                A_PUP:   s_d.rdata = s_q.pup;
                A_FLAG:  s_d.rdata = s_q.flag;
                A_CAP:   s_d.rdata = s_q.cap;
                A_PORT:  s_d.rdata = view;
                A_OLAT:  s_d.rdata = s_q.olat;
                default: s_d.rdata = '0;
            endcase
        end

        if (bus_we) begin
            case (ea)
                A_DIR:          s_d.dir  = bus_wdata;
                A_POL:          s_d.pol  = bus_wdata;
                A_IEN:          s_d.ien  = bus_wdata;
                A_DEFV:         s_d.defv = bus_wdata;
                A_ICTL:         s_d.ictl = bus_wdata;
                A_CFG:          s_d.cfg  = bus_wdata;
                A_PUP:          s_d.pup  = bus_wdata;
                A_PORT, A_OLAT: s_d.olat = bus_wdata;
                default: ;
            endcase
        end

        if (bus_we || bus_re) begin
            if (s_q.cfg[CFG_SEQ_OFF])
                s_d.ptr = ea;
            else if (ea >= LAST_A)
                s_d.ptr = '0;
            else
                s_d.ptr = ea + 8'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.dir <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;
    assign pin_out   = s_q.olat;
    assign pin_oe    = ~s_q.dir;
endmodule

// File: rtl/gpx_core_chk.sv
module gpx_core_chk
    import gpx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input gpx_state_t st,
    input logic [7:0] bus_addr,
    input logic       bus_re,
    input logic       bus_seq,
    input logic       irq_out,
    input logic       irq_oe
);
    logic [7:0] ea_c;
    logic       clr_c;
    assign ea_c  = bus_seq ? st.ptr : bus_addr;
    assign clr_c = bus_re && ((ea_c == A_PORT && !st.cfg[CFG_ICC]) ||
                              (ea_c == A_CAP  &&  st.cfg[CFG_ICC]));

    a_r7_flag_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st.flag));

    a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st.flag != '0 && !clr_c) |=> (st.flag == $past(st.flag)));

    a_r8_cap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st.flag != '0 && !clr_c) |=> $stable(st.cap));

    a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_c |=> (st.flag == '0));

    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st.flag == '0 && st.ien == '0) |=> (st.flag == '0));

    a_r12_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
        st.cfg[CFG_ODR] |-> (irq_out == 1'b0 && irq_oe == (st.flag != '0)));
endmodule

bind gpx_core gpx_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st(s_q), .bus_addr(bus_addr),
    .bus_re(bus_re), .bus_seq(bus_seq), .irq_out(irq_out), .irq_oe(irq_oe)
);

// File: tb/tb_gpx_core.sv
`timescale 1ns/1ps
module tb_gpx_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, pin_in = '0;
    logic       bus_we = 1'b0, bus_re = 1'b0, bus_seq = 1'b0;
    logic [7:0] bus_rdata, pin_out, pin_oe;
    logic       irq_out, irq_oe;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpx_core dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_seq(bus_seq),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_out(irq_out), .irq_oe(irq_oe)
    );

    // behavioural reference model
    logic [7:0] mreg [0:10];
    logic [7:0] mflag, mcap, mprev, mrd, mptr;

    function automatic logic [7:0] mview();
        logic [7:0] v;
        for (int i = 0; i < 8; i++)
            v[i] = mreg[0][i] ? (pin_in[i] ^ mreg[1][i]) : mreg[10][i];
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= 10; i++) mreg[i] = 8'h00;
            mreg[0] = 8'hFF;
            mflag = 0; mcap = 0; mprev = 0; mrd = 0; mptr = 0;
        end else begin
            int ea, hit;
            logic [7:0] v, nflag, ncap, nrd;
            bit clr;
            ea = bus_seq ? int'(mptr) : int'(bus_addr);
            v = mview();
            hit = -1;
            for (int i = 7; i >= 0; i--) begin
                bit m;
                m = mreg[4][i] ? (v[i] != mreg[3][i]) : (v[i] != mprev[i]);
                if (mreg[2][i] && mreg[0][i] && m) hit = i;
            end
            clr = bus_re && ((ea == 9 && !mreg[5][0]) || (ea == 8 && mreg[5][0]));
            nflag = mflag; ncap = mcap; nrd = mrd;
            if (clr) nflag = 0;
            else if (mflag == 0 && hit >= 0) begin
                nflag = 8'(1 << hit); ncap = v;
            end
            if (bus_re) begin
                if (ea == 7) nrd = mflag;
                else if (ea == 8) nrd = mcap;
                else if (ea == 9) nrd = v;
                else if (ea <= 10) nrd = mreg[ea];
                else nrd = 0;
            end
            if (bus_re || bus_we)
                mptr = mreg[5][5] ? 8'(ea) : (ea >= 10 ? 8'd0 : 8'(ea + 1));
            if (bus_we) begin
                if (ea <= 6 || ea == 10) mreg[ea] = bus_wdata;
                else if (ea == 9) mreg[10] = bus_wdata;
            end
            mflag = nflag; mcap = ncap; mrd = nrd; mprev = v;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) if (rst_n && !done) begin
        logic eo, ee;
        bit act;
        act = (mflag != 0);
        ee = mreg[5][2] ? act : 1'b1;
        eo = mreg[5][2] ? 1'b0 : (act ? mreg[5][1] : ~mreg[5][1]);
        n_chk++;
        if (bus_rdata !== mrd || pin_out !== mreg[10] || pin_oe !== ~mreg[0] ||
            irq_out !== eo || irq_oe !== ee) begin
            n_fail++;
            $display("FAIL R11/R12 model: rd=%h/%h out=%h/%h oe=%h/%h irq=%b%b/%b%b",
                     bus_rdata, mrd, pin_out, mreg[10], pin_oe, ~mreg[0],
                     irq_out, irq_oe, eo, ee);
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit seq = 0);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1; bus_seq = seq;
        @(negedge clk);
        bus_we = 0; bus_seq = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d, input bit seq = 0);
        @(negedge clk);
        bus_addr = a; bus_re = 1; bus_seq = seq;
        @(negedge clk);
        bus_re = 0; bus_seq = 0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle(1);
        // R1 reset state
        rd(8'h00, d); chk("R1 dir reset", d, 8'hFF);
        rd(8'h05, d); chk("R1 cfg reset", d, 8'h00);
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 irq idle", {6'b0, irq_out, irq_oe}, 8'h03);
        // R2 readback
        wr(8'h01, 8'h0F); rd(8'h01, d); chk("R2 pol readback", d, 8'h0F);
        wr(8'h06, 8'hC3); rd(8'h06, d); chk("R2 pullup readback", d, 8'hC3);
        // R3 read-only and out of range
        wr(8'h07, 8'h55); rd(8'h07, d); chk("R3 flag ro", d, 8'h00);
        wr(8'h08, 8'h55); rd(8'h08, d); chk("R3 cap ro", d, 8'h00);
        wr(8'h20, 8'h77); rd(8'h20, d); chk("R3 out of range", d, 8'h00);
        // R11 port view
        wr(8'h00, 8'hF0); wr(8'h0A, 8'hA5);
        pin_in = 8'h3C; idle(1);
        chk("R11 pin_oe", pin_oe, 8'h0F);
        chk("R11 pin_out", pin_out, 8'hA5);
        rd(8'h09, d); chk("R11 port mix", d, 8'h35);
        rd(8'h0A, d); chk("R11 latch read", d, 8'hA5);
        wr(8'h09, 8'h5A); rd(8'h0A, d); chk("R11 port write to latch", d, 8'h5A);
        // back to all inputs, no polarity
        wr(8'h00, 8'hFF); wr(8'h01, 8'h00); pin_in = 8'h00; idle(2);
        // R4 disabled pin
        pin_in = 8'h01; idle(3);
        rd(8'h07, d); chk("R4 disabled no flag", d, 8'h00);
        chk("R4 irq idle", {7'b0, irq_out}, 8'h01);
        pin_in = 8'h00; idle(2);
        // R5 / R7 / R8 compare to previous
        wr(8'h02, 8'hFF);
        pin_in = 8'h06; idle(2);
        chk("R5 irq active low", {7'b0, irq_out}, 8'h00);
        rd(8'h07, d); chk("R7 lowest pin flagged", d, 8'h02);
        pin_in = 8'h0E; idle(2);
        rd(8'h07, d); chk("R7 no extra flag", d, 8'h02);
        rd(8'h08, d); chk("R8 capture frozen", d, 8'h06);
        rd(8'h07, d); chk("R9 cap read no clear cc0", d, 8'h02);
        rd(8'h09, d); chk("R9 port read value", d, 8'h0E);
        rd(8'h07, d); chk("R9 port read cleared", d, 8'h00);
        // R6 / R10 compare to default, clear via capture
        wr(8'h04, 8'h10); wr(8'h05, 8'h01);
        pin_in = 8'h1E; idle(2);
        rd(8'h07, d); chk("R6 default mismatch", d, 8'h10);
        rd(8'h09, d); rd(8'h07, d); chk("R9 port read no clear cc1", d, 8'h10);
        rd(8'h08, d); chk("R8 capture value", d, 8'h1E);
        rd(8'h07, d); chk("R10 re-raise after clear", d, 8'h10);
        // R12 polarity and open drain
        wr(8'h05, 8'h03); idle(1);
        chk("R12 active high", {6'b0, irq_out, irq_oe}, 8'h03);
        wr(8'h05, 8'h05); idle(1);
        chk("R12 od pending", {6'b0, irq_out, irq_oe}, 8'h01);
        wr(8'h03, 8'h10); idle(1);
        rd(8'h08, d); idle(1);
        chk("R12 od released", {6'b0, irq_out, irq_oe}, 8'h00);
        // R13 sequential addressing
        wr(8'h02, 8'h00); wr(8'h05, 8'h00);
        rd(8'h0A, d);
        rd(8'h00, d, 1); chk("R13 wrap to 0", d, 8'hFF);
        rd(8'h00, d, 1); chk("R13 increment", d, 8'h00);
        wr(8'h05, 8'h20);
        rd(8'h03, d); rd(8'h00, d, 1); chk("R13 seq off holds", d, 8'h10);
        idle(2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule